// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the program counter of a core whose instructions are a fixed 32 bits long. Each cycle in which the decode stage presents a valid instruction, the unit chooses the address of the next fetch. It can step to the next word, take a PC-relative branch that compares two register values, jump to an absolute target inside the current 256 MB region, or jump to an address read from a register. Without a valid instruction the PC stays where it is.

For the two linking jumps, the unit asks the register file to write a return address. The write carries its own enable, a fixed destination index of 31 and the value PC+4. A register jump to an address that is not word aligned does not move the PC. The unit raises a misaligned-fetch flag for that cycle instead. A synchronous reset loads a reset vector that is set by a parameter.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC loads `RESET_VEC` (default 32'h0000_0100) at that edge and `link_we_o` is low.
- R2: When `valid_i` is low, the PC keeps its value across the edge, and both `link_we_o` and `misalign_o` are low.
- R3: Sequential step: the PC becomes PC+4 modulo 2^32 for any valid instruction that is not a control transfer. This covers every opcode other than 0, 2, 3, 4 and 5, and opcode 0 with a function code other than 8 or 9.
- R4: BEQ (opcode 4): when `rs_val_i == rt_val_i`, the PC becomes PC+4 plus the sign-extended 16-bit offset multiplied by 4. Otherwise the PC becomes PC+4.
- R5: BNE (opcode 5): the branch is taken when `rs_val_i != rt_val_i`, with the same target arithmetic as R4. Otherwise the PC becomes PC+4.
- R6: J (opcode 2): bits 31:28 of the PC come from PC+4, bits 27:2 from the 26-bit target and bits 1:0 are zero.
- R7: JR (opcode 0, function code 8): the PC becomes `rs_val_i` when bits 1:0 of that value are zero.
- R8: JAL (opcode 3) jumps as in R6, and JALR (opcode 0, function code 9) jumps as in R7. In the cycle the instruction is presented, both set `link_we_o`=1, `link_idx_o`=31 and `link_data_o`=PC+4.
- R9: For JR or JALR with `rs_val_i[1:0]` nonzero, `misalign_o` is 1 in that cycle, the PC is held, and `link_we_o` is 0.
- R10: `link_we_o` is high only for JAL and JALR. `link_idx_o` always reads 31, so register 0 is never a link destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction fields are valid this cycle |
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function code for opcode 0 |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| offset_i | input | 16 | Signed branch offset in words |
| target_i | input | 26 | Absolute jump target field |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index (always 31) |
| link_data_o | output | 32 | Return address written on link |
| misalign_o | output | 1 | Register jump target not word aligned |

## Verification
If the decoder sends a control instruction down the wrong path, `pc_o` shows the wrong address one edge after the instruction. The bench compares it to an address it computes itself. A wrong comparison sense on a branch, a bad sign extension or a wrong choice of region bits shows up the same way, after one step. The link and misalign outputs are combinational from the current fields and PC. Faults in them are therefore visible in the same cycle the instruction is presented, before the PC moves. Any bad PC value persists, and it is carried into every sequential step that follows.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int PC_W   = 32;
  localparam int OFF_W  = 16;
  localparam int TGT_W  = 26;
  localparam int OP_W   = 6;
  localparam int IDX_W  = 5;
  localparam int REGION_W = PC_W - TGT_W - 2;

  localparam logic [OP_W-1:0] OP_REGFMT = 6'd0;
  localparam logic [OP_W-1:0] OP_JABS   = 6'd2;
  localparam logic [OP_W-1:0] OP_JLINK  = 6'd3;
  localparam logic [OP_W-1:0] OP_BREQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_BRNE   = 6'd5;
  localparam logic [OP_W-1:0] FN_JREG   = 6'd8;
  localparam logic [OP_W-1:0] FN_JRLINK = 6'd9;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JABS,
    FLOW_JREG
  } flow_kind_e;

  function automatic logic [PC_W-1:0] seq_addr(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  function automatic logic [PC_W-1:0] branch_addr(input logic [PC_W-1:0] pc4,
                                                  input logic [OFF_W-1:0] off);
    logic [PC_W-1:0] disp;
    disp = {{(PC_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return pc4 + disp;
  endfunction

  function automatic logic [PC_W-1:0] jump_addr(input logic [PC_W-1:0] pc4,
                                                input logic [TGT_W-1:0] tgt);
    return {pc4[PC_W-1 -: REGION_W], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  input  logic [OP_W-1:0] funct_i,
  output flow_kind_e      kind_o,
  output logic            is_link_o
);

  always_comb begin
    kind_o    = FLOW_SEQ;
    is_link_o = 1'b0;
    unique case (opcode_i)
      OP_REGFMT: begin
        if (funct_i == FN_JREG) begin
          kind_o = FLOW_JREG;
        end else if (funct_i == FN_JRLINK) begin
          kind_o    = FLOW_JREG;
          is_link_o = 1'b1;
        end
      end
      OP_JABS:  kind_o = FLOW_JABS;
      OP_JLINK: begin
        kind_o    = FLOW_JABS;
        is_link_o = 1'b1;
      end
      OP_BREQ:  kind_o = FLOW_BREQ;
      OP_BRNE:  kind_o = FLOW_BRNE;
      default:  kind_o = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
(
  input  logic [PC_W-1:0]  pc_i,
  input  flow_kind_e       kind_i,
  input  logic [PC_W-1:0]  rs_val_i,
  input  logic [PC_W-1:0]  rt_val_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [TGT_W-1:0] target_i,
  output logic [PC_W-1:0]  pc4_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             misalign_raw_o
);

  logic            same_vals;
  logic [PC_W-1:0] br_dest;
  logic [PC_W-1:0] jabs_dest;

  assign pc4_o     = seq_addr(pc_i);
  assign same_vals = (rs_val_i == rt_val_i);
  assign br_dest   = branch_addr(pc4_o, offset_i);
  assign jabs_dest = jump_addr(pc4_o, target_i);

  always_comb begin
    next_pc_o      = pc4_o;
    taken_o        = 1'b0;
    misalign_raw_o = 1'b0;
    unique case (kind_i)
      FLOW_BREQ: taken_o = same_vals;
      FLOW_BRNE: taken_o = !same_vals;
      FLOW_JABS: taken_o = 1'b1;
      FLOW_JREG: begin
        taken_o        = 1'b1;
        misalign_raw_o = |rs_val_i[1:0];
      end
      default:   taken_o = 1'b0;
    endcase
    if (taken_o) begin
      unique case (kind_i)
        FLOW_JABS: next_pc_o = jabs_dest;
        FLOW_JREG: next_pc_o = rs_val_i;
        default:   next_pc_o = br_dest;
      endcase
    end
  end

endmodule

// File: rtl/nextpc_pcreg.sv
module nextpc_pcreg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VEC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] pc_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= RESET_VEC;
    end else if (load_i) begin
      pc_o <= next_i;
    end
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0100,
  parameter logic [4:0]  LINK_IDX  = 5'd31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid_i,
  input  logic [5:0]  opcode_i,
  input  logic [5:0]  funct_i,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  input  logic [15:0] offset_i,
  input  logic [25:0] target_i,
  output logic [31:0] pc_o,
  output logic        link_we_o,
  output logic [4:0]  link_idx_o,
  output logic [31:0] link_data_o,
  output logic        misalign_o
);

  flow_kind_e      kind;
  logic            is_link;
  logic [PC_W-1:0] pc4;
  logic [PC_W-1:0] next_pc;
  logic            taken;
  logic            misalign_raw;
  logic            advance;

  // Named events for the checker
  logic            ev_seq;
  logic            ev_regjump;

  nextpc_decode u_decode (
    .opcode_i  (opcode_i),
    .funct_i   (funct_i),
    .kind_o    (kind),
    .is_link_o (is_link)
  );

  nextpc_target u_target (
    .pc_i           (pc_o),
    .kind_i         (kind),
    .rs_val_i       (rs_val_i),
    .rt_val_i       (rt_val_i),
    .offset_i       (offset_i),
    .target_i       (target_i),
    .pc4_o          (pc4),
    .next_pc_o      (next_pc),
    .taken_o        (taken),
    .misalign_raw_o (misalign_raw)
  );

  assign misalign_o = valid_i && !rst && misalign_raw;
  assign advance    = valid_i && !misalign_raw;

  nextpc_pcreg #(.W(PC_W), .RESET_VEC(RESET_VEC)) u_pcreg (
    .clk    (clk),
    .rst    (rst),
    .load_i (advance),
    .next_i (next_pc),
    .pc_o   (pc_o)
  );

  assign link_we_o   = valid_i && !rst && is_link && !misalign_raw && taken;
  assign link_idx_o  = LINK_IDX;
  assign link_data_o = pc4;

  assign ev_seq      = valid_i && (kind == FLOW_SEQ);
  assign ev_regjump  = valid_i && (kind == FLOW_JREG);

endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
  input logic        clk,
  input logic        rst,
  input logic        valid_i,
  input logic [5:0]  opcode_i,
  input logic [5:0]  funct_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [31:0] pc_o,
  input logic        link_we_o,
  input logic [4:0]  link_idx_o,
  input logic [31:0] link_data_o,
  input logic        misalign_o,
  input logic        ev_seq,
  input logic        ev_regjump
);

  p_reset_vec_r1: assert property (@(posedge clk) rst |=> pc_o == RESET_VEC);
  p_reset_nolink_r1: assert property (@(posedge clk) rst |-> !link_we_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> pc_o == $past(pc_o));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> (!link_we_o && !misalign_o));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    ev_seq |=> pc_o == $past(pc_o) + 32'd4);

  p_beq_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i == 6'd4 && rs_val_i != rt_val_i) |=> pc_o == $past(pc_o) + 32'd4);

  p_bne_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i == 6'd5 && rs_val_i == rt_val_i) |=> pc_o == $past(pc_o) + 32'd4);

  p_jr_load_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_regjump && !misalign_o) |=> pc_o == $past(rs_val_i));

  p_link_data_r8: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_data_o == pc_o + 32'd4));

  p_misalign_hold_r9: assert property (@(posedge clk) disable iff (rst)
    misalign_o |=> $stable(pc_o));
  p_misalign_nolink_r9: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> !link_we_o);

  p_link_only_r10: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (valid_i && (opcode_i == 6'd3 || (opcode_i == 6'd0 && funct_i == 6'd9))));
  p_link_idx_r10: assert property (@(posedge clk) link_idx_o == 5'd31);

endmodule

bind nextpc_unit nextpc_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .valid_i     (valid_i),
  .opcode_i    (opcode_i),
  .funct_i     (funct_i),
  .rs_val_i    (rs_val_i),
  .rt_val_i    (rt_val_i),
  .pc_o        (pc_o),
  .link_we_o   (link_we_o),
  .link_idx_o  (link_idx_o),
  .link_data_o (link_data_o),
  .misalign_o  (misalign_o),
  .ev_seq      (ev_seq),
  .ev_regjump  (ev_regjump)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;

  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [5:0]  funct_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [15:0] offset_i = '0;
  logic [25:0] target_i = '0;
  logic [31:0] pc_o;
  logic        link_we_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_data_o;
  logic        misalign_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  logic [31:0] model_pc;

  always #4 clk = ~clk;

  nextpc_unit #(.RESET_VEC(RV)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i), .funct_i(funct_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .offset_i(offset_i), .target_i(target_i),
    .pc_o(pc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
    .link_data_o(link_data_o), .misalign_o(misalign_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present fields at the falling edge and let combinational outputs settle
  task automatic issue(input logic v, input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] off, input logic [25:0] tgt);
    @(negedge clk);
    valid_i = v; opcode_i = op; funct_i = fn;
    rs_val_i = a; rt_val_i = b; offset_i = off; target_i = tgt;
    #1;
  endtask

  task automatic step_edge();
    @(posedge clk);
    #1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic set_pc(input logic [31:0] addr);
    issue(1'b1, 6'd0, 6'd8, addr, 32'd0, 16'd0, 26'd0);
    step_edge();
    model_pc = addr;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    issue(1'b1, 6'd3, 6'd0, 32'd0, 32'd0, 16'd0, 26'h123);
    check("R1 link_we during reset", {31'd0, link_we_o}, 32'd0);
    step_edge();
    check("R1 pc after reset", pc_o, RV);
    rst = 1'b0;
    model_pc = RV;
  endtask

  task automatic t_idle();
    set_pc(32'h0000_4000);
    issue(1'b0, 6'd3, 6'd0, 32'h3, 32'd0, 16'd5, 26'h55);
    check("R2 no link when idle", {31'd0, link_we_o}, 32'd0);
    check("R2 no misalign when idle", {31'd0, misalign_o}, 32'd0);
    step_edge();
    check("R2 pc held when idle", pc_o, model_pc);
  endtask

  task automatic t_seq();
    set_pc(32'h0000_2000);
    issue(1'b1, 6'h23, 6'd0, 32'd1, 32'd2, 16'hFFFF, 26'h3FFFFFF);
    check("R3 no link on load opcode", {31'd0, link_we_o}, 32'd0);
    step_edge();
    model_pc = model_pc + 32'd4;
    check("R3 sequential after load opcode", pc_o, model_pc);
    issue(1'b1, 6'd0, 6'h20, 32'd1, 32'd1, 16'd0, 26'd0);
    check("R10 no link on register-format add", {31'd0, link_we_o}, 32'd0);
    step_edge();
    model_pc = model_pc + 32'd4;
    check("R3 sequential after register-format add", pc_o, model_pc);
    set_pc(32'hFFFF_FFFC);
    issue(1'b1, 6'h08, 6'd0, 32'd0, 32'd0, 16'd0, 26'd0);
    step_edge();
    check("R3 wrap at top of space", pc_o, 32'h0000_0000);
  endtask

  function automatic logic [31:0] exp_branch(input logic [31:0] pc, input logic [15:0] off);
    logic signed [31:0] words;
    words = 32'($signed(off));
    return pc + 32'd4 + 32'(words * 4);
  endfunction

  task automatic t_beq();
    set_pc(32'h0000_1000);
    issue(1'b1, 6'd4, 6'd0, 32'hAAAA_5555, 32'hAAAA_5555, 16'd16, 26'd0);
    step_edge();
    check("R4 beq taken forward", pc_o, exp_branch(32'h0000_1000, 16'd16));
    set_pc(32'h0000_1000);
    issue(1'b1, 6'd4, 6'd0, 32'd7, 32'd7, 16'hFFF0, 26'd0);
    step_edge();
    check("R4 beq taken backward", pc_o, exp_branch(32'h0000_1000, 16'hFFF0));
    set_pc(32'h0000_1000);
    issue(1'b1, 6'd4, 6'd0, 32'd7, 32'd8, 16'h0040, 26'd0);
    step_edge();
    check("R4 beq not taken", pc_o, 32'h0000_1004);
  endtask

  task automatic t_bne();
    set_pc(32'h0000_3000);
    issue(1'b1, 6'd5, 6'd0, 32'd1, 32'd2, 16'h8000, 26'd0);
    step_edge();
    check("R5 bne taken most negative offset", pc_o, exp_branch(32'h0000_3000, 16'h8000));
    set_pc(32'h0000_3000);
    issue(1'b1, 6'd5, 6'd0, 32'd9, 32'd9, 16'h0100, 26'd0);
    step_edge();
    check("R5 bne not taken", pc_o, 32'h0000_3004);
  endtask

  task automatic t_jabs();
    set_pc(32'h7000_0010);
    issue(1'b1, 6'd2, 6'd0, 32'd0, 32'd0, 16'd0, 26'h2AB_CDEF);
    check("R10 no link on plain jump", {31'd0, link_we_o}, 32'd0);
    step_edge();
    check("R6 jump region bits", pc_o, (32'h7000_0014 & 32'hF000_0000) | (32'h2AB_CDEF * 4));
    set_pc(32'h0FFF_FFFC);
    issue(1'b1, 6'd2, 6'd0, 32'd0, 32'd0, 16'd0, 26'h000_0004);
    step_edge();
    check("R6 jump region from PC+4 crossing", pc_o, 32'h1000_0010);
  endtask

  task automatic t_jr();
    set_pc(32'h0000_5000);
    issue(1'b1, 6'd0, 6'd8, 32'h1234_5678, 32'd0, 16'd0, 26'd0);
    check("R7 jr no link", {31'd0, link_we_o}, 32'd0);
    step_edge();
    check("R7 jr loads register", pc_o, 32'h1234_5678);
  endtask

  task automatic t_link();
    set_pc(32'h4000_0200);
    issue(1'b1, 6'd3, 6'd0, 32'd0, 32'd0, 16'd0, 26'h010_0000);
    check("R8 jal link enable", {31'd0, link_we_o}, 32'd1);
    check("R8 jal link index", {27'd0, link_idx_o}, 32'd31);
    check("R8 jal link data", link_data_o, 32'h4000_0204);
    step_edge();
    check("R8 jal target", pc_o, 32'h4040_0000);
    set_pc(32'h0000_8000);
    issue(1'b1, 6'd0, 6'd9, 32'h0000_9A00, 32'd0, 16'd0, 26'd0);
    check("R8 jalr link enable", {31'd0, link_we_o}, 32'd1);
    check("R8 jalr link data", link_data_o, 32'h0000_8004);
    step_edge();
    check("R8 jalr target", pc_o, 32'h0000_9A00);
  endtask

  task automatic t_misalign();
    set_pc(32'h0000_6000);
    issue(1'b1, 6'd0, 6'd8, 32'h0000_7002, 32'd0, 16'd0, 26'd0);
    check("R9 jr misalign flag", {31'd0, misalign_o}, 32'd1);
    step_edge();
    check("R9 jr misaligned holds pc", pc_o, 32'h0000_6000);
    issue(1'b1, 6'd0, 6'd9, 32'h0000_7001, 32'd0, 16'd0, 26'd0);
    check("R9 jalr misalign flag", {31'd0, misalign_o}, 32'd1);
    check("R9 jalr misaligned suppresses link", {31'd0, link_we_o}, 32'd0);
    step_edge();
    check("R9 jalr misaligned holds pc", pc_o, 32'h0000_6000);
    issue(1'b1, 6'h0F, 6'd0, 32'h0000_0003, 32'd0, 16'd0, 26'd0);
    check("R9 no misalign on non-jump", {31'd0, misalign_o}, 32'd0);
    step_edge();
  endtask

  task automatic t_reset_midrun();
    set_pc(32'h0000_ABC0);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_seq();
    t_beq();
    t_bne();
    t_jabs();
    t_jr();
    t_link();
    t_misalign();
    t_reset_midrun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule